// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This unit takes a 32-bit virtual address together with the current privilege level, an error-level status flag, the access direction (load or store) and a mapping-mode select. From these it classifies the address into one of five fixed address windows. For each request it decides one of three outcomes. The address may be translated directly, by masking or offsetting, with both read and write granted. It may instead need a lookup in the translation buffer, which sits outside this block. Otherwise the access is refused with an address error, whose type follows the access direction.

The block can also run in a fixed-mapping mode, used on cores without a translation buffer. In that mode every address maps arithmetically, so no lookup and no privilege check is needed.

Requests enter on a valid/ready stream and results leave on a valid/ready stream. An accepted request produces its registered result on the next cycle. `in_ready` is high whenever the result register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the result holds steady and no new request is taken. With `out_ready` tied high, each accepted request gives exactly one cycle of `out_valid`.

Top module: `vseg_decoder`

## Requirements
- R1: In standard mode, with the error-level flag clear, an address in 0x00000000..0x7FFFFFFF raises `out_tlb_req` in every privilege level, with no fault, a zero physical address and no permissions.
- R2: In standard mode, with the error-level flag set, an address in 0x00000000..0x7FFFFFFF passes through unchanged, with read and write granted and no lookup requested.
- R3: In kernel level, an address in 0x80000000..0x9FFFFFFF maps to the address minus 0x80000000, and an address in 0xA0000000..0xBFFFFFFF maps to the address minus 0xA0000000. Both grant read and write.
- R4: In supervisor or user level, any address in 0x80000000..0xBFFFFFFF gives an address error.
- R5: An address in 0xC0000000..0xDFFFFFFF requests a lookup in kernel or supervisor level and gives an address error in user level.
- R6: An address in 0xE0000000..0xFFFFFFFF requests a lookup in kernel level only and gives an address error otherwise.
- R7: In fixed-mapping mode (`fixed_map`=1), an address in 0x00000000..0x7FFFFFFF maps to the address plus 0x40000000 when the error-level flag is clear, and unchanged when it is set. Read and write are granted in any privilege level.
- R8: In fixed-mapping mode, 0x80000000..0xBFFFFFFF maps to the address AND 0x1FFFFFFF and higher addresses pass through unchanged. Read and write are granted, with no lookup and no fault in any level.
- R9: `out_fault` is encoded 0 = none, 1 = load-type error, 2 = store-type error. Store-type is used when `in_store`=1. A faulting result has zero physical address, no permissions and no lookup.
- R10: `priv_mode` is 00 kernel, 01 supervisor, 10 user. The code 11 behaves exactly as user.
- R11: A request accepted at a clock edge appears on the outputs after that edge with `out_valid` high. While `out_valid`=1 and `out_ready`=0, `in_ready` is low and the outputs hold. With no request, `out_valid` falls after the result is taken.
- R12: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_vaddr | input | 32 | Virtual address |
| in_store | input | 1 | 1 = store access, 0 = load or fetch |
| priv_mode | input | 2 | Privilege level: 00 kernel, 01 supervisor, 10/11 user |
| err_level | input | 1 | Error-level status flag |
| fixed_map | input | 1 | 1 selects fixed-mapping mode |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result when high |
| out_paddr | output | 32 | Physical address for directly mapped results |
| out_tlb_req | output | 1 | Address must be translated by the lookup buffer |
| out_rd_ok | output | 1 | Read permitted |
| out_wr_ok | output | 1 | Write permitted |
| out_fault | output | 2 | Address error code (see R9) |

## Verification
The only register on the path is the result register, so every classification result is due one clock edge after the request is accepted. The bench drives each request on a falling edge and reads the outputs at the next falling edge. It then drops `in_valid` and reads again one cycle later to confirm that `out_valid` fell. For back-pressure, the bench holds `out_ready` low for several cycles, presents a second request, and samples at each falling edge that the first result is unchanged and `in_ready` stays low. After releasing `out_ready`, it expects the second result exactly one edge later.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  localparam int VA_W    = 32;
  localparam int SEL_W   = 3;
  localparam int FAULT_W = 2;

  typedef enum logic [1:0] {
    PRIV_KERN   = 2'b00,
    PRIV_SUP    = 2'b01,
    PRIV_USER   = 2'b10,
    PRIV_USER_X = 2'b11
  } priv_e;

  typedef enum logic [2:0] {
    SEG_USER      = 3'd0,
    SEG_KDIR_CACH = 3'd1,
    SEG_KDIR_UNC  = 3'd2,
    SEG_SUP_MAP   = 3'd3,
    SEG_KERN_MAP  = 3'd4
  } seg_e;

  typedef enum logic [FAULT_W-1:0] {
    FLT_NONE  = 2'd0,
    FLT_LOAD  = 2'd1,
    FLT_STORE = 2'd2
  } fault_e;

  typedef struct packed {
    logic [VA_W-1:0] paddr;
    logic            tlb;
    logic            rd;
    logic            wr;
    fault_e          fault;
  } xlate_t;
endpackage

// File: rtl/vseg_classify.sv
module vseg_classify
  import vseg_pkg::*;
(
  input  logic [VA_W-1:0] vaddr,
  output seg_e            seg
);
  logic [SEL_W-1:0] sel;
  assign sel = vaddr[VA_W-1 -: SEL_W];

  always_comb begin
    casez (sel)
      3'b0??:  seg = SEG_USER;
      3'b100:  seg = SEG_KDIR_CACH;
      3'b101:  seg = SEG_KDIR_UNC;
      3'b110:  seg = SEG_SUP_MAP;
      default: seg = SEG_KERN_MAP;
    endcase
  end
endmodule

// File: rtl/vseg_priv_check.sv
module vseg_priv_check
  import vseg_pkg::*;
(
  input  seg_e       seg,
  input  logic [1:0] priv_mode,
  output logic       allowed
);
  logic is_kern, is_sup, is_user;

  assign is_kern = (priv_mode == PRIV_KERN);
  assign is_sup  = (priv_mode == PRIV_SUP);
  assign is_user = !is_kern && !is_sup;

  always_comb begin
    case (seg)
      SEG_USER:      allowed = 1'b1;
      SEG_KDIR_CACH: allowed = is_kern;
      SEG_KDIR_UNC:  allowed = is_kern;
      SEG_SUP_MAP:   allowed = is_kern || is_sup;
      SEG_KERN_MAP:  allowed = is_kern;
      default:       allowed = 1'b0;
    endcase
  end

  // R10: both user encodings are refused every privileged window
  always_comb begin
    if (is_user && seg != SEG_USER)
      p_user_refused_r10: assert (!allowed);
  end
endmodule

// File: rtl/vseg_map.sv
module vseg_map
  import vseg_pkg::*;
#(
  parameter logic [VA_W-1:0] FIXED_OFFSET   = 32'h4000_0000,
  parameter logic [VA_W-1:0] DIRECT_MASK    = 32'h1FFF_FFFF,
  parameter bit              HAS_FIXED_MODE = 1'b1
) (
  input  logic [VA_W-1:0] vaddr,
  input  seg_e            seg,
  input  logic            err_level,
  input  logic            fixed_map,
  input  logic            allowed,
  input  logic            is_store,
  output xlate_t          result
);
  logic   fixed_sel;
  xlate_t std_res;
  xlate_t fix_res;

  generate
    if (HAS_FIXED_MODE) begin : g_fixed
      assign fixed_sel = fixed_map;
    end else begin : g_no_fixed
      logic unused_fixed;
      assign unused_fixed = fixed_map;
      assign fixed_sel    = 1'b0;
    end
  endgenerate

  // Standard privilege-gated decode
  always_comb begin
    std_res = '0;
    case (seg)
      SEG_USER: begin
        if (err_level) begin
          std_res.paddr = vaddr;
          std_res.rd    = 1'b1;
          std_res.wr    = 1'b1;
        end else begin
          std_res.tlb   = 1'b1;
        end
      end
      SEG_KDIR_CACH, SEG_KDIR_UNC: begin
        if (allowed) begin
          std_res.paddr = vaddr & DIRECT_MASK;
          std_res.rd    = 1'b1;
          std_res.wr    = 1'b1;
        end
      end
      default: begin
        if (allowed) std_res.tlb = 1'b1;
      end
    endcase
    if (!allowed) std_res.fault = is_store ? FLT_STORE : FLT_LOAD;
  end

  // Fixed arithmetic mapping, no lookup and no gating
  always_comb begin
    fix_res    = '0;
    fix_res.rd = 1'b1;
    fix_res.wr = 1'b1;
    case (seg)
      SEG_USER:                    fix_res.paddr = err_level ? vaddr : vaddr + FIXED_OFFSET;
      SEG_KDIR_CACH, SEG_KDIR_UNC: fix_res.paddr = vaddr & DIRECT_MASK;
      default:                     fix_res.paddr = vaddr;
    endcase
  end

  assign result = fixed_sel ? fix_res : std_res;
endmodule

// File: rtl/vseg_decoder.sv
module vseg_decoder
  import vseg_pkg::*;
#(
  parameter logic [VA_W-1:0] FIXED_OFFSET   = 32'h4000_0000,
  parameter logic [VA_W-1:0] DIRECT_MASK    = 32'h1FFF_FFFF,
  parameter bit              HAS_FIXED_MODE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [VA_W-1:0] in_vaddr,
  input  logic            in_store,
  input  logic [1:0]      priv_mode,
  input  logic            err_level,
  input  logic            fixed_map,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VA_W-1:0] out_paddr,
  output logic            out_tlb_req,
  output logic            out_rd_ok,
  output logic            out_wr_ok,
  output logic [1:0]      out_fault
);
  seg_e   seg;
  logic   allowed;
  xlate_t next_res;
  xlate_t res_q;
  logic   valid_q;

  vseg_classify u_classify (
    .vaddr (in_vaddr),
    .seg   (seg)
  );

  vseg_priv_check u_priv (
    .seg       (seg),
    .priv_mode (priv_mode),
    .allowed   (allowed)
  );

  vseg_map #(
    .FIXED_OFFSET   (FIXED_OFFSET),
    .DIRECT_MASK    (DIRECT_MASK),
    .HAS_FIXED_MODE (HAS_FIXED_MODE)
  ) u_map (
    .vaddr     (in_vaddr),
    .seg       (seg),
    .err_level (err_level),
    .fixed_map (fixed_map),
    .allowed   (allowed),
    .is_store  (in_store),
    .result    (next_res)
  );

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) res_q <= next_res;
    end
  end

  assign out_valid   = valid_q;
  assign out_paddr   = res_q.paddr;
  assign out_tlb_req = res_q.tlb;
  assign out_rd_ok   = res_q.rd;
  assign out_wr_ok   = res_q.wr;
  assign out_fault   = res_q.fault;

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_paddr) && $stable(out_fault)
                                && $stable(out_tlb_req));

  p_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && in_ready |=> !out_valid);

  p_fault_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault != 2'd0 |-> !out_tlb_req && !out_rd_ok && !out_wr_ok
                                       && out_paddr == '0);

  p_lookup_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_tlb_req |-> !out_rd_ok && !out_wr_ok && out_fault == 2'd0);
endmodule

// File: tb/test_vseg_decoder.sv
module test_vseg_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_vaddr = '0;
  logic        in_store = 1'b0;
  logic [1:0]  priv_mode = 2'b00;
  logic        err_level = 1'b0;
  logic        fixed_map = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_paddr;
  logic        out_tlb_req;
  logic        out_rd_ok;
  logic        out_wr_ok;
  logic [1:0]  out_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vseg_decoder i_vseg_decoder (
    .clk, .rst_n, .in_valid, .in_ready, .in_vaddr, .in_store, .priv_mode,
    .err_level, .fixed_map, .out_valid, .out_ready, .out_paddr, .out_tlb_req,
    .out_rd_ok, .out_wr_ok, .out_fault
  );

  logic [31:0] addrs [16] = '{32'h0000_0000, 32'h1234_5678, 32'h4000_0000, 32'h7FFF_FFFF,
                              32'h8000_0000, 32'h8ABC_DEF0, 32'h9FFF_FFFF, 32'hA000_0000,
                              32'hB135_7911, 32'hBFFF_FFFF, 32'hC000_0000, 32'hD00D_F00D,
                              32'hDFFF_FFFF, 32'hE000_0000, 32'hF0F0_1234, 32'hFFFF_FFFF};

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] a, input logic [1:0] m, input logic erl,
                       input logic st, input logic fx,
                       output logic [31:0] pa, output logic tlb, output logic rw,
                       output logic [1:0] flt, output string tag);
    logic kern, usr, bad;
    kern = (m == 2'b00);
    usr  = (m[1] == 1'b1);
    pa = 0; tlb = 0; rw = 0; flt = 0; bad = 0;
    if (fx) begin
      rw = 1;
      if (a <= 32'h7FFF_FFFF) begin pa = erl ? a : a + 32'h4000_0000; tag = "R7"; end
      else if (a <= 32'hBFFF_FFFF) begin pa = a & 32'h1FFF_FFFF; tag = "R8"; end
      else begin pa = a; tag = "R8"; end
    end else if (a <= 32'h7FFF_FFFF) begin
      if (erl) begin pa = a; rw = 1; tag = "R2"; end
      else begin tlb = 1; tag = "R1"; end
    end else if (a < 32'hA000_0000) begin
      if (kern) begin pa = a - 32'h8000_0000; rw = 1; tag = "R3"; end
      else begin bad = 1; tag = "R4"; end
    end else if (a < 32'hC000_0000) begin
      if (kern) begin pa = a - 32'hA000_0000; rw = 1; tag = "R3"; end
      else begin bad = 1; tag = "R4"; end
    end else if (a < 32'hE000_0000) begin
      tag = "R5";
      if (!usr) tlb = 1; else bad = 1;
    end else begin
      tag = "R6";
      if (kern) tlb = 1; else bad = 1;
    end
    if (bad) begin
      flt = st ? 2'd2 : 2'd1;
      tag = {tag, "/R9"};
    end
    if (m == 2'b11) tag = {tag, "/R10"};
  endtask

  task automatic run_one(input logic [31:0] a, input logic [1:0] m, input logic erl,
                         input logic st, input logic fx);
    logic [31:0] pa;
    logic tlb, rw;
    logic [1:0] flt;
    string tag;
    model(a, m, erl, st, fx, pa, tlb, rw, flt, tag);
    in_vaddr = a; priv_mode = m; err_level = erl; in_store = st; fixed_map = fx;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b1 || out_paddr !== pa || out_tlb_req !== tlb ||
        out_rd_ok !== rw || out_wr_ok !== rw || out_fault !== flt) begin
      errors++;
      $display("FAIL %s a=%h m=%0d erl=%0b st=%0b fx=%0b: actual v=%0b pa=%h tlb=%0b rd=%0b wr=%0b f=%0d expected v=1 pa=%h tlb=%0b rd=%0b wr=%0b f=%0d",
               tag, a, m, erl, st, fx, out_valid, out_paddr, out_tlb_req, out_rd_ok,
               out_wr_ok, out_fault, pa, tlb, rw, rw, flt);
    end
    @(negedge clk);
    check_bit("R11 valid pulse ends", out_valid, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check_bit("R12 out_valid in reset", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R12 out_valid after reset", out_valid, 1'b0);
    check_bit("R12 in_ready after reset", in_ready, 1'b1);

    // Sweep: every sample address, level, flag, direction and mode
    for (int ai = 0; ai < 16; ai++)
      for (int m = 0; m < 4; m++)
        for (int e = 0; e < 2; e++)
          for (int s = 0; s < 2; s++)
            for (int f = 0; f < 2; f++)
              run_one(addrs[ai], 2'(m), 1'(e), 1'(s), 1'(f));

    // R11 back-pressure: hold first result, refuse second until drained
    out_ready = 1'b0;
    in_vaddr = 32'h8000_1000; priv_mode = 2'b00; err_level = 0; in_store = 0; fixed_map = 0;
    in_valid = 1'b1;
    @(negedge clk);
    in_vaddr = 32'hA000_2000;
    for (int k = 0; k < 3; k++) begin
      check_bit("R11 in_ready low under stall", in_ready, 1'b0);
      check_bit("R11 out_valid held", out_valid, 1'b1);
      checks++;
      if (out_paddr !== 32'h0000_1000) begin
        errors++;
        $display("FAIL R11 held paddr: actual %h expected %h", out_paddr, 32'h0000_1000);
      end
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R11 second result valid", out_valid, 1'b1);
    checks++;
    if (out_paddr !== 32'h0000_2000) begin
      errors++;
      $display("FAIL R11 second paddr: actual %h expected %h", out_paddr, 32'h0000_2000);
    end
    @(negedge clk);
    check_bit("R11 drained", out_valid, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule